// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Condition Flags and Condition Evaluator

This block is the execute-stage arithmetic core of a small 32-bit processor. A 4-bit operation code picks one of four operations on two operand words, X and Y: addition, subtraction (Y less X), bitwise AND and bitwise XOR. The result word is purely combinational. The operation also produces zero, sign and signed-overflow flags.

Those flags are captured into a three-bit condition register on a rising clock edge, but only when the load strobe is high and the operation code is a valid one. The registered flags are visible on the ports.

A second 4-bit condition code is evaluated against the registered flags. It yields one "condition holds" bit, which serves both conditional register moves and conditional jumps. Operand selection, instruction decode and the register file sit outside this block.

Top module: `alu_cc_unit`

## Requirements
- R1: Operation code 0 drives `aluResult` combinationally with X+Y, modulo 2^32.
- R2: Operation code 1 drives `aluResult` combinationally with Y-X, modulo 2^32.
- R3: Operation code 2 gives X AND Y and code 3 gives X XOR Y; for both, the overflow flag captured is 0.
- R4: Operation codes 4 to 15 give a result of 0 and leave all three registered flags unchanged, even with `setCc` high.
- R5: Flags change only on a rising clock edge with `setCc` high and a valid operation code; at all other times they hold.
- R6: The zero flag is captured as 1 exactly when the result is 0, and the sign flag is captured as result bit 31.
- R7: For addition, overflow is captured as 1 when X and Y share a sign and the result's sign differs from it.
- R8: For subtraction, overflow is captured as 1 when X and Y differ in sign and the result's sign differs from that of Y.
- R9: While `rstN` is low the flags are zero=1, sign=0, overflow=0.
- R10: With the condition code in 0..6, `condTrue` is: 0 always 1; 1 (sign^ovf)|zero; 2 sign^ovf; 3 zero; 4 !zero; 5 !(sign^ovf); 6 !(sign^ovf)&!zero. It is computed from the registered flags.
- R11: Condition codes 7 to 15 give `condTrue` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the flags |
| aluFn | input | 4 | Operation code |
| opX | input | 32 | Operand X |
| opY | input | 32 | Operand Y |
| setCc | input | 1 | Flag load strobe |
| condFn | input | 4 | Condition code to evaluate |
| aluResult | output | 32 | Combinational operation result |
| zeroFlag | output | 1 | Registered zero flag |
| signFlag | output | 1 | Registered sign flag |
| ovfFlag | output | 1 | Registered overflow flag |
| condTrue | output | 1 | Condition evaluation of `condFn` against the registered flags |

## Verification
The assertions take for granted that operands, operation code and load strobe are settled before each rising edge. The flag checks compare the registered value with the combinational result of the previous cycle.

The stimulus therefore changes inputs only at the falling edge. It samples the combinational result shortly after driving, and samples the flags shortly after the next rising edge.

All sixteen condition codes are evaluated against every flag pattern that the vectors produce. The load strobe is deliberately held high while invalid operation codes are applied.

// File: rtl/alu_cc_pkg.sv
package alu_cc_pkg;

  localparam int DATA_W = 32;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } aluOp_e;

  typedef enum logic [CODE_W-1:0] {
    CND_ALWAYS = 4'd0,
    CND_LE     = 4'd1,
    CND_LT     = 4'd2,
    CND_EQ     = 4'd3,
    CND_NE     = 4'd4,
    CND_GE     = 4'd5,
    CND_GT     = 4'd6
  } cond_e;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;

  typedef struct packed {
    aluOp_e op;
    logic   opValid;
    logic   loadFlags;
  } strobe_t;

  localparam flags_t FLAGS_RESET = '{zf: 1'b1, sf: 1'b0, of: 1'b0};

endpackage

// File: rtl/alu_cc_control.sv
module alu_cc_control
  import alu_cc_pkg::*;
#(
  parameter int CODE_W_P = CODE_W
) (
  input  logic [CODE_W_P-1:0] aluFn,
  input  logic                setCc,
  output strobe_t             strobe
);

  localparam int NUM_OPS = 4;

  always_comb begin
    strobe.op      = OP_ADD;
    strobe.opValid = 1'b0;
    if (aluFn < CODE_W_P'(NUM_OPS)) begin
      strobe.op      = aluOp_e'(aluFn[1:0]);
      strobe.opValid = 1'b1;
    end
    strobe.loadFlags = setCc && strobe.opValid;
  end

  // R4: an invalid code never requests a flag load
  always_comb begin
    a_r4_no_load_on_bad: assert (!(aluFn >= CODE_W_P'(NUM_OPS) && strobe.loadFlags))
      else $error("load strobe raised for invalid operation code");
  end

endmodule

// File: rtl/alu_cc_datapath.sv
module alu_cc_datapath
  import alu_cc_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] opX,
  input  logic [WIDTH-1:0] opY,
  input  strobe_t          strobe,
  output logic [WIDTH-1:0] result,
  output flags_t           flags
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] sumOut;
  logic [WIDTH-1:0] diffOut;
  logic             addOvf;
  logic             subOvf;
  flags_t           nextFlags;

  assign sumOut  = opX + opY;
  assign diffOut = opY - opX;
  assign addOvf  = (opX[MSB] == opY[MSB]) && (sumOut[MSB] != opX[MSB]);
  assign subOvf  = (opX[MSB] != opY[MSB]) && (diffOut[MSB] != opY[MSB]);

  always_comb begin
    result       = '0;
    nextFlags.of = 1'b0;
    if (strobe.opValid) begin
      unique case (strobe.op)
        OP_ADD: begin result = sumOut;  nextFlags.of = addOvf; end
        OP_SUB: begin result = diffOut; nextFlags.of = subOvf; end
        OP_AND: result = opX & opY;
        OP_XOR: result = opX ^ opY;
        default: result = '0;
      endcase
    end
    nextFlags.zf = (result == '0);
    nextFlags.sf = result[MSB];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 flags <= FLAGS_RESET;
    else if (strobe.loadFlags) flags <= nextFlags;
  end

  // R5: without a load the flags hold
  a_r5_flags_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadFlags |=> $stable(flags));

  // R6: captured zero and sign follow the previous result
  a_r6_zero_sign: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadFlags |=> (flags.zf == ($past(result) == '0)) && (flags.sf == $past(result[MSB])));

  // R3: logic operations clear overflow
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.loadFlags && (strobe.op == OP_AND || strobe.op == OP_XOR)) |=> !flags.of);

  // R4: invalid code yields a zero result
  a_r4_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.opValid |-> (result == '0));

endmodule

// File: rtl/alu_cc_cond.sv
module alu_cc_cond
  import alu_cc_pkg::*;
#(
  parameter int CODE_W_P = CODE_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [CODE_W_P-1:0] condFn,
  input  flags_t              flags,
  output logic                condTrue
);

  logic lessThan;
  assign lessThan = flags.sf ^ flags.of;

  always_comb begin
    case (condFn)
      CND_ALWAYS: condTrue = 1'b1;
      CND_LE:     condTrue = lessThan | flags.zf;
      CND_LT:     condTrue = lessThan;
      CND_EQ:     condTrue = flags.zf;
      CND_NE:     condTrue = !flags.zf;
      CND_GE:     condTrue = !lessThan;
      CND_GT:     condTrue = !lessThan && !flags.zf;
      default:    condTrue = 1'b0;
    endcase
  end

  // R10: equality follows the registered zero flag
  a_r10_equal_tracks_zero: assert property (@(posedge clk) disable iff (!rstN)
    (condFn == CND_EQ) |-> (condTrue == flags.zf));

  // R11: codes above 6 never hold
  a_r11_unknown_false: assert property (@(posedge clk) disable iff (!rstN)
    (condFn > CND_GT) |-> !condTrue);

endmodule

// File: rtl/alu_cc_unit.sv
module alu_cc_unit
  import alu_cc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] aluFn,
  input  logic [DATA_W-1:0] opX,
  input  logic [DATA_W-1:0] opY,
  input  logic              setCc,
  input  logic [CODE_W-1:0] condFn,
  output logic [DATA_W-1:0] aluResult,
  output logic              zeroFlag,
  output logic              signFlag,
  output logic              ovfFlag,
  output logic              condTrue
);

  strobe_t strobe;
  flags_t  flags;

  alu_cc_control #(.CODE_W_P(CODE_W)) u_control (
    .aluFn  (aluFn),
    .setCc  (setCc),
    .strobe (strobe)
  );

  alu_cc_datapath #(.WIDTH(DATA_W)) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .opX    (opX),
    .opY    (opY),
    .strobe (strobe),
    .result (aluResult),
    .flags  (flags)
  );

  alu_cc_cond #(.CODE_W_P(CODE_W)) u_cond (
    .clk      (clk),
    .rstN     (rstN),
    .condFn   (condFn),
    .flags    (flags),
    .condTrue (condTrue)
  );

  assign zeroFlag = flags.zf;
  assign signFlag = flags.sf;
  assign ovfFlag  = flags.of;

endmodule

// File: tb/alu_cc_unit_bench.sv
module alu_cc_unit_bench;

  typedef struct packed {
    logic [3:0]  fn;
    logic [31:0] x;
    logic [31:0] y;
    logic [31:0] res;
    logic        z;
    logic        s;
    logic        o;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{4'd0, 32'h00000001, 32'h00000002, 32'h00000003, 1'b0, 1'b0, 1'b0},
    '{4'd0, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1, 1'b1},
    '{4'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0, 1'b0},
    '{4'd0, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b0, 1'b1},
    '{4'd1, 32'h00000003, 32'h0000000A, 32'h00000007, 1'b0, 1'b0, 1'b0},
    '{4'd1, 32'h00000005, 32'h00000003, 32'hFFFFFFFE, 1'b0, 1'b1, 1'b0},
    '{4'd1, 32'h00000001, 32'h80000000, 32'h7FFFFFFF, 1'b0, 1'b0, 1'b1},
    '{4'd1, 32'hFFFFFFFF, 32'h7FFFFFFF, 32'h80000000, 1'b0, 1'b1, 1'b1},
    '{4'd2, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b1, 1'b0},
    '{4'd3, 32'hAAAAAAAA, 32'hAAAAAAAA, 32'h00000000, 1'b1, 1'b0, 1'b0},
    '{4'd3, 32'h12345678, 32'hF0000000, 32'hE2345678, 1'b0, 1'b1, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  aluFn = '0;
  logic [31:0] opX = '0;
  logic [31:0] opY = '0;
  logic        setCc = 1'b0;
  logic [3:0]  condFn = '0;
  logic [31:0] aluResult;
  logic        zeroFlag, signFlag, ovfFlag, condTrue;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  alu_cc_unit u_alu_cc_unit (
    .clk(clk), .rstN(rstN), .aluFn(aluFn), .opX(opX), .opY(opY),
    .setCc(setCc), .condFn(condFn), .aluResult(aluResult),
    .zeroFlag(zeroFlag), .signFlag(signFlag), .ovfFlag(ovfFlag),
    .condTrue(condTrue)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkFlags(input string tag, input logic z, input logic s, input logic o);
    check({zeroFlag, signFlag, ovfFlag} === {z, s, o}, tag,
          {29'd0, zeroFlag, signFlag, ovfFlag}, {29'd0, z, s, o});
  endtask

  function automatic logic condModel(input logic [3:0] c, input logic z, input logic s, input logic o);
    case (c)
      4'd0: return 1'b1;
      4'd1: return (s ^ o) | z;
      4'd2: return s ^ o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !(s ^ o);
      4'd6: return !(s ^ o) && !z;
      default: return 1'b0;
    endcase
  endfunction

  // R10 and R11: sweep every condition code against expected flags
  task automatic sweepConds(input logic z, input logic s, input logic o);
    for (int c = 0; c < 16; c++) begin
      condFn = 4'(c);
      #1;
      check(condTrue === condModel(4'(c), z, s, o), (c < 7) ? "R10 condition" : "R11 unknown condition",
            {31'd0, condTrue}, {31'd0, condModel(4'(c), z, s, o)});
    end
  endtask

  initial begin
    #(20 * 5000);
    $display("FAIL watchdog expired actual=running expected=done");
    nFails++;
    nChecks++;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    // R9: reset state
    checkFlags("R9 reset flags", 1'b1, 1'b0, 1'b0);
    sweepConds(1'b1, 1'b0, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      aluFn = VECS[i].fn; opX = VECS[i].x; opY = VECS[i].y; setCc = 1'b1;
      #1;
      // R1 R2 R3: combinational result
      check(aluResult === VECS[i].res, "R1 R2 R3 result", aluResult, VECS[i].res);
      @(posedge clk); #1;
      // R6 R7 R8 R3: captured flags
      checkFlags("R6 R7 R8 R3 flags", VECS[i].z, VECS[i].s, VECS[i].o);
      sweepConds(VECS[i].z, VECS[i].s, VECS[i].o);
    end

    // Load Z0 S1 O1 from vector 1
    @(negedge clk);
    aluFn = 4'd0; opX = 32'h7FFFFFFF; opY = 32'h1; setCc = 1'b1;
    @(posedge clk); #1;
    checkFlags("R7 preload", 1'b0, 1'b1, 1'b1);

    // R4: invalid codes with load strobe high
    for (int f = 4; f < 16; f++) begin
      @(negedge clk);
      aluFn = 4'(f); opX = 32'h0; opY = 32'h0; setCc = 1'b1;
      #1;
      check(aluResult === 32'h0, "R4 invalid result", aluResult, 32'h0);
      @(posedge clk); #1;
      checkFlags("R4 invalid flags held", 1'b0, 1'b1, 1'b1);
    end

    // R5: a zero-producing add without the strobe does not load
    @(negedge clk);
    aluFn = 4'd0; opX = 32'h0; opY = 32'h0; setCc = 1'b0;
    @(posedge clk); #1;
    checkFlags("R5 hold without strobe", 1'b0, 1'b1, 1'b1);

    // R5: flags do not move before the edge
    @(negedge clk);
    setCc = 1'b1;
    #1;
    checkFlags("R5 no change before edge", 1'b0, 1'b1, 1'b1);
    @(posedge clk); #1;
    checkFlags("R5 load on edge", 1'b1, 1'b0, 1'b0);

    // R9: asynchronous reset restores the reset flags
    @(negedge clk);
    aluFn = 4'd1; opX = 32'h1; opY = 32'h0; setCc = 1'b1;
    @(posedge clk); #1;
    checkFlags("R8 negative preload", 1'b0, 1'b1, 1'b0);
    rstN = 1'b0;
    #1;
    checkFlags("R9 reset reapplied", 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule